// File: doc/BRIEF.md
# Input Pulse Period Capture

This block watches one digital input, chosen from a bank of candidate signals by a small selector, and measures its timing in clock ticks. At 100 MHz, one tick is 10 ns. Three results are published as plain register outputs. The first is the length of the latest finished low phase. The second is the length of the latest finished high phase. The third is a live count of ticks since the last edge of either polarity. Several pulse-width channels can read the same results, so there is one selected source and one result set for all of them.

The chosen input first passes through a two-flop synchroniser. Edges are then found by comparing each synchronised sample with the one before it. A rising edge stores the elapsed phase as the low length. A falling edge stores it as the high length. Both edge types restart the live count.

Changing the selector throws away the phase that was being measured. After a change, the block ignores edges until the synchroniser holds only the new source. The last finished high and low lengths stay readable. Every counter stops at its maximum value and does not wrap.

Top module: `pulse_period_capture`

## Requirements
- R1: While reset is low, `lowLen`, `highLen` and `sinceEdge` all read 0.
- R2: A selector value n picks `srcIn[n]` as the measured input; the other `srcIn` bits have no effect on any output.
- R3: `sinceEdge` grows by one per clock and returns to 0 on each detected edge. A change of the raw input applied before clock edge p is detected at clock edge p+2 (two synchroniser flops, then the compare).
- R4: On a detected rising edge, `lowLen` becomes the number of clocks the synchronised input was low.
- R5: On a detected falling edge, `highLen` becomes the number of clocks the synchronised input was high.
- R6: `sinceEdge` and the stored lengths saturate at the all-ones value of the counter width (default 32 bits) instead of wrapping.
- R7: The first edge detected after reset, or after a selector change, only restarts `sinceEdge`; it stores no length.
- R8: A selector change clears `sinceEdge` at the next clock and holds it at 0 for a settle window of SYNC_STAGES+1 further clocks. During that window `lowLen` and `highLen` keep their values.
- R9: `lowLen` and `highLen` never change on the same clock, and a length changes only on a clock where `sinceEdge` returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one period is one measurement tick |
| rstN | input | 1 | Active-low synchronous reset |
| srcSel | input | SEL_W (3) | Index of the measured input |
| srcIn | input | 2**SEL_W (8) | Candidate input signals, asynchronous |
| lowLen | output | CNT_W (32) | Ticks in the latest completed low phase |
| highLen | output | CNT_W (32) | Ticks in the latest completed high phase |
| sinceEdge | output | CNT_W (32) | Ticks since the last detected edge |

## Verification
The bound checker covers the cycle-level rules on every clock:
- the live count only rises or returns to 0, and stays put once saturated;
- a length register moves only when the live count restarts, and never both on one clock;
- a selector change always clears the count and leaves both lengths alone.

Some behaviour only the bench scenarios can show:
- the exact length values for given phase widths, including one-tick phases;
- that inputs other than the selected one are ignored;
- that the first edge after reset or after a selector change stores nothing;
- saturation, shown on a narrow-counter instance.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

  // Strobes from the control side to the counting datapath
  typedef struct packed {
    logic discard;  // selector changed or synchroniser still settling
    logic rise;     // qualified rising edge of the synchronised input
    logic fall;     // qualified falling edge of the synchronised input
  } ppc_strobe_t;

endpackage

// File: rtl/ppc_ctrl.sv
module ppc_ctrl
  import ppc_pkg::*;
#(
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [SEL_W-1:0]       srcSel,
  input  logic [(1<<SEL_W)-1:0]  srcIn,
  output ppc_strobe_t            strobe
);

  localparam int SETTLE   = SYNC_STAGES + 1;
  localparam int SETTLE_W = $clog2(SETTLE + 1);

  logic                   selBit;
  logic [SYNC_STAGES-1:0] syncPipe;
  logic                   syncQ;
  logic                   prevQ;
  logic [SEL_W-1:0]       prevSel;
  logic [SETTLE_W-1:0]    settleCnt;
  logic                   selChange;
  logic                   settling;

  assign selBit = srcIn[srcSel];

  // Synchroniser chain, one flop per stage
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncPipe[0] <= 1'b0;
          else       syncPipe[0] <= selBit;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rstN) syncPipe[gi] <= 1'b0;
          else       syncPipe[gi] <= syncPipe[gi-1];
        end
      end
    end
  endgenerate

  assign syncQ = syncPipe[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevQ   <= 1'b0;
      prevSel <= '0;
    end else begin
      prevQ   <= syncQ;
      prevSel <= srcSel;
    end
  end

  assign selChange = (srcSel != prevSel);
  assign settling  = (settleCnt != '0);

  // Hold off edge detection until the pipe carries only the new source
  always_ff @(posedge clk) begin
    if (!rstN)          settleCnt <= '0;
    else if (selChange) settleCnt <= SETTLE_W'(SETTLE);
    else if (settling)  settleCnt <= settleCnt - 1'b1;
  end

  always_comb begin
    strobe.discard = selChange | settling;
    strobe.rise    = ~strobe.discard & syncQ & ~prevQ;
    strobe.fall    = ~strobe.discard & ~syncQ & prevQ;
  end

endmodule

// File: rtl/ppc_datapath.sv
module ppc_datapath
  import ppc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ppc_strobe_t      strobe,
  output logic [CNT_W-1:0] lowLen,
  output logic [CNT_W-1:0] highLen,
  output logic [CNT_W-1:0] sinceEdge
);

  logic [CNT_W-1:0] edgeCnt;
  logic [CNT_W-1:0] satInc;
  logic             armed;
  logic             anyEdge;

  assign satInc  = (edgeCnt == '1) ? edgeCnt : edgeCnt + 1'b1;
  assign anyEdge = strobe.rise | strobe.fall;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgeCnt <= '0;
      armed   <= 1'b0;
    end else if (strobe.discard) begin
      edgeCnt <= '0;
      armed   <= 1'b0;
    end else if (anyEdge) begin
      edgeCnt <= '0;
      armed   <= 1'b1;
    end else begin
      edgeCnt <= satInc;
    end
  end

  // The phase that just ended counts the edge cycle itself, hence satInc
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowLen  <= '0;
      highLen <= '0;
    end else if (armed) begin
      if (strobe.rise) lowLen  <= satInc;
      if (strobe.fall) highLen <= satInc;
    end
  end

  assign sinceEdge = edgeCnt;

endmodule

// File: rtl/pulse_period_capture.sv
module pulse_period_capture
  import ppc_pkg::*;
#(
  parameter int SEL_W       = 3,
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [SEL_W-1:0]      srcSel,
  input  logic [(1<<SEL_W)-1:0] srcIn,
  output logic [CNT_W-1:0]      lowLen,
  output logic [CNT_W-1:0]      highLen,
  output logic [CNT_W-1:0]      sinceEdge
);

  ppc_strobe_t strobe;

  ppc_ctrl #(
    .SEL_W      (SEL_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .srcSel(srcSel),
    .srcIn (srcIn),
    .strobe(strobe)
  );

  ppc_datapath #(
    .CNT_W(CNT_W)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .lowLen   (lowLen),
    .highLen  (highLen),
    .sinceEdge(sinceEdge)
  );

endmodule

// File: rtl/ppc_checker.sv
module ppc_checker #(
  parameter int SEL_W = 3,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [SEL_W-1:0] srcSel,
  input logic [CNT_W-1:0] lowLen,
  input logic [CNT_W-1:0] highLen,
  input logic [CNT_W-1:0] sinceEdge
);

  // R3: the live count only grows or restarts
  assert_count_monotone_R3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (sinceEdge >= $past(sinceEdge)) || (sinceEdge == '0));

  // R6: once at the top the count stays there until an edge
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sinceEdge == '1) |=> (sinceEdge == '1) || (sinceEdge == '0));

  // R8: selector change clears the count and keeps the stored lengths
  assert_sel_change_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(srcSel) |=> (sinceEdge == '0) && $stable(lowLen) && $stable(highLen));

  // R9: a length moves only together with a count restart
  assert_low_on_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lowLen) |-> (sinceEdge == '0));

  assert_high_on_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(highLen) |-> (sinceEdge == '0));

  assert_one_length_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lowLen) |-> $stable(highLen));

endmodule

bind pulse_period_capture ppc_checker #(
  .SEL_W(SEL_W),
  .CNT_W(CNT_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .srcSel   (srcSel),
  .lowLen   (lowLen),
  .highLen  (highLen),
  .sinceEdge(sinceEdge)
);

// File: tb/tb_pulse_period_capture.sv
module tb_pulse_period_capture;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  srcSel = '0;
  logic [7:0]  srcIn = '0;
  logic [31:0] lowLen, highLen, sinceEdge;
  logic [7:0]  nLow, nHigh, nSince;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pulse_period_capture dut (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .srcIn(srcIn),
    .lowLen(lowLen), .highLen(highLen), .sinceEdge(sinceEdge)
  );

  // Narrow-counter copy used to reach saturation quickly
  pulse_period_capture #(.CNT_W(8)) dutNarrow (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .srcIn(srcIn),
    .lowLen(nLow), .highLen(nHigh), .sinceEdge(nSince)
  );

  // {sel, low ticks, high ticks}
  localparam logic [23:0] VECS [8] = '{
    24'h00_03_05, 24'h01_01_01, 24'h02_01_04, 24'h03_0A_02,
    24'h04_02_11, 24'h05_28_28, 24'h06_07_01, 24'h07_01_09
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Selected bit gets lvl, all other bits get the opposite level (noise)
  task automatic drive(input logic [2:0] sel, input logic lvl);
    srcIn = lvl ? (8'h01 << sel) : ~(8'h01 << sel);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    ticks(3);
    check("R1 lowLen", lowLen, 0);
    check("R1 highLen", highLen, 0);
    check("R1 sinceEdge", sinceEdge, 0);
    rstN = 1'b1;
    ticks(10);
    check("R3 count after reset", sinceEdge, 10);

    // First edge after reset only restarts the count (R7)
    srcIn = 8'h01;
    ticks(5);
    check("R7 no latch after reset", lowLen, 0);
    check("R3 edge restart delay", sinceEdge, 2);

    // Vector table: high H, low L, high, then read back
    for (int i = 0; i < 8; i++) begin
      logic [2:0] sel;
      int lo, hi;
      sel = VECS[i][18:16];
      lo  = int'(VECS[i][15:8]);
      hi  = int'(VECS[i][7:0]);
      srcSel = sel;
      drive(sel, 1'b0);
      ticks(8);
      drive(sel, 1'b1);
      ticks(hi);
      drive(sel, 1'b0);
      ticks(lo);
      drive(sel, 1'b1);
      ticks(5);
      check("R5 highLen R2", highLen, 32'(hi));
      check("R4 lowLen R2", lowLen, 32'(lo));
      check("R3 sinceEdge", sinceEdge, 2);
    end

    // Selector change mid-phase (R8, R7); source 7 currently high
    srcSel = 3'd2;
    srcIn  = 8'h04;
    ticks(2);
    check("R8 count cleared", sinceEdge, 0);
    check("R8 lowLen kept", lowLen, 1);
    check("R8 highLen kept", highLen, 9);
    ticks(6);
    srcIn = 8'hFB;
    ticks(7);
    check("R7 no latch after select change", highLen, 9);
    srcIn = 8'h04;
    ticks(5);
    check("R4 low after change", lowLen, 7);
    check("R3 sinceEdge after change", sinceEdge, 2);

    // Saturation on the narrow copy (R6)
    srcIn = 8'h00;
    ticks(300);
    check("R6 narrow count saturates", 32'(nSince), 255);
    check("R3 wide count", sinceEdge, 297);
    srcIn = 8'h04;
    ticks(5);
    check("R6 narrow lowLen saturates", 32'(nLow), 255);
    check("R4 wide lowLen", lowLen, 300);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule